// File: doc/BRIEF.md
# Shared-Pin Serial Slave Port

This block is the device side of a two-wire serial link that uses one data pin in both directions. A host drives the serial clock and an active-low frame select. It shifts a 16-bit command word into the block, most significant bit first. The block then takes over the pin and shifts a 16-bit result word back out. When that word is done, it returns the pin to the host after a short turnaround. Each received word goes to the surrounding logic as a parallel value with a one-clock valid strobe. The result word is taken from a parallel input at the moment its first bit goes out.

All pins are oversampled by a faster system clock through two-flop synchronizers. A polarity input selects which serial clock edge captures data and which edge launches it. The frame select can be pulsed for each word, or it can be tied low for good. When it is tied low, the pin is never released and the direction flips at each word boundary.

A command word sent with the calibration request raised starts a multi-word burst. During a read burst the pin stays an output for every word. During a write burst it stays an input for every word. The burst length comes from a 3-bit input that is latched with the command, and a burst cannot be cut short.

Top module: `bsp_port`

## Requirements
- R1: After reset the pin is an input: dataOe is 0 and rxValid is 0.
- R2: With polarity = 1, dataIn is captured on rising sclkIn edges while frameNIn is low, MSB first. After the 16th capture, rxWord holds the word and rxValid is high for exactly one system clock.
- R3: With polarity = 0, capture moves to falling edges and launch moves to rising edges. Otherwise the behaviour is the same as R2.
- R4: After the 16th capture of an ordinary write word, the block owns the pin. dataOe is 1 while frameNIn is low and 0 while frameNIn is high.
- R5: In an output word, the first launch edge (falling when polarity = 1) loads resultWord and presents bit 15. Each later launch edge presents the next lower bit.
- R6: After the 16th capture edge of an ordinary output word, dataOe stays 1 for TURN_CYC system clocks (default 2). The pin then returns to input, and a new write word is accepted.
- R7: With frameNIn held low throughout, dataOe never drops during an output word. The direction alternates at every 16th capture edge.
- R8: A command word written with calReq = 1 and calRead = 1 starts a read burst of calWords + 1 output words. dataOe stays 1 across the word boundaries whenever frameNIn is low. The pin returns to input only after the last word.
- R9: A command word written with calReq = 1 and calRead = 0 starts a write burst. calWords + 1 data words follow, each with its own rxValid, and dataOe stays 0 throughout. After the last one the pin becomes an output for one ordinary word.
- R10: calReq, calRead and calWords are latched at the first bit of a command word and ignored for the rest of the burst. Raising frameNIn between burst words tri-states the pin but does not end the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclkIn | input | 1 | Serial clock from the host |
| frameNIn | input | 1 | Active-low frame select from the host |
| polarity | input | 1 | 1: capture on rising and launch on falling; 0: swapped |
| dataIn | input | 1 | Pin value seen by the receiver |
| resultWord | input | 16 | Word to be shifted out in the next output word |
| calReq | input | 1 | Marks the current command word as a calibration burst |
| calRead | input | 1 | Burst direction: 1 read, 0 write |
| calWords | input | 3 | Burst length minus one, in words |
| rxWord | output | 16 | Last received word |
| rxValid | output | 1 | One-clock strobe when rxWord updates |
| dataOut | output | 1 | Value driven on the pin |
| dataOe | output | 1 | Output-driver enable for the pin |

## Verification
Words are exchanged with a pulsed frame under both clock polarities. Swapping the polarity separates the capture edge from the launch edge, and the asymmetric data patterns expose bit-order and off-by-one-edge faults. A run with the frame tied low shows that the direction turns at the 16th capture without any tri-state gap. A three-word read burst, which also carries a frame pulse and altered request inputs, tells a held direction from an ordinary per-word turnaround. A two-word write burst shows that the pin stays an input until the last data word, with one strobe per word.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  typedef struct packed {
    logic sample;   // capture one incoming bit
    logic lastBit;  // current capture completes a word
    logic load;     // first launch of an output word
    logic shift;    // later launch of an output word
  } bsp_strobe_t;
endpackage

// File: rtl/bsp_datapath.sv
module bsp_datapath
  import bsp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              frameNIn,
  input  logic              dataIn,
  input  logic              polarity,
  input  logic [WORD_W-1:0] resultWord,
  input  bsp_strobe_t       strb,
  output logic              capEdge,
  output logic              lchEdge,
  output logic              frameLow,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxValid,
  output logic              dataOut
);
  // bit 0 sclk, bit 1 frame select, bit 2 data
  logic [2:0] syncPipe [SYNC_STAGES];
  logic sclkPrev;
  logic sclkS, dinS, riseS, fallS;
  logic [WORD_W-1:0] rxShift, txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncPipe[i] <= 3'b010;
      sclkPrev <= 1'b0;
    end else begin
      syncPipe[0] <= {dataIn, frameNIn, sclkIn};
      for (int i = 1; i < SYNC_STAGES; i++) syncPipe[i] <= syncPipe[i-1];
      sclkPrev <= sclkS;
    end
  end

  assign sclkS    = syncPipe[SYNC_STAGES-1][0];
  assign frameLow = ~syncPipe[SYNC_STAGES-1][1];
  assign dinS     = syncPipe[SYNC_STAGES-1][2];
  assign riseS    = sclkS & ~sclkPrev;
  assign fallS    = ~sclkS & sclkPrev;
  assign capEdge  = frameLow & (polarity ? riseS : fallS);
  assign lchEdge  = frameLow & (polarity ? fallS : riseS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxWord  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strb.sample) begin
        rxShift <= {rxShift[WORD_W-2:0], dinS};
        if (strb.lastBit) begin
          rxWord  <= {rxShift[WORD_W-2:0], dinS};
          rxValid <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txShift <= '0;
    else if (strb.load)   txShift <= resultWord;
    else if (strb.shift)  txShift <= {txShift[WORD_W-2:0], 1'b0};
  end

  assign dataOut = txShift[WORD_W-1];

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  a_r2_word_held: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxWord));
endmodule

// File: rtl/bsp_control.sv
module bsp_control
  import bsp_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int BURST_W  = 3,
  parameter int TURN_CYC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               capEdge,
  input  logic               lchEdge,
  input  logic               frameLow,
  input  logic               calReq,
  input  logic               calRead,
  input  logic [BURST_W-1:0] calWords,
  output bsp_strobe_t        strb,
  output logic               dataOe
);
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int TURN_W = $clog2(TURN_CYC + 1);

  logic               dirOut, turning, lastBit, wordEnd;
  logic [TURN_W-1:0]  turnCnt;
  logic [CNT_W-1:0]   bitCnt;
  logic               pendCal, pendRd, inBurst, burstRd;
  logic [BURST_W-1:0] pendLen, burstLeft;

  assign lastBit      = bitCnt == CNT_W'(WORD_W - 1);
  assign wordEnd      = capEdge & lastBit & ~turning;
  assign strb.sample  = capEdge & ~dirOut;
  assign strb.lastBit = lastBit;
  assign strb.load    = lchEdge & dirOut & ~turning & (bitCnt == '0);
  assign strb.shift   = lchEdge & dirOut & ~turning & (bitCnt != '0);
  assign dataOe       = dirOut & frameLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      bitCnt <= '0;
    else if (!frameLow)             bitCnt <= '0;
    else if (capEdge && !turning)   bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirOut <= 1'b0; turning <= 1'b0; turnCnt <= '0;
      pendCal <= 1'b0; pendRd <= 1'b0; pendLen <= '0;
      inBurst <= 1'b0; burstRd <= 1'b0; burstLeft <= '0;
    end else if (turning) begin
      if (turnCnt <= TURN_W'(1)) begin
        turning <= 1'b0;
        dirOut  <= 1'b0;
      end else begin
        turnCnt <= turnCnt - 1'b1;
      end
    end else if (capEdge) begin
      if (!dirOut) begin
        if (bitCnt == '0 && !inBurst) begin
          pendCal <= calReq;
          pendRd  <= calRead;
          pendLen <= calWords;
        end
        if (lastBit) begin
          if (inBurst) begin
            if (burstLeft == '0) begin
              inBurst <= 1'b0;
              dirOut  <= 1'b1;
            end else begin
              burstLeft <= burstLeft - 1'b1;
            end
          end else if (pendCal) begin
            inBurst   <= 1'b1;
            burstRd   <= pendRd;
            burstLeft <= pendLen;
            pendCal   <= 1'b0;
            dirOut    <= pendRd;
          end else begin
            dirOut <= 1'b1;
          end
        end
      end else if (lastBit) begin
        if (inBurst && burstRd && burstLeft != '0) begin
          burstLeft <= burstLeft - 1'b1;
        end else begin
          inBurst <= 1'b0;
          turning <= 1'b1;
          turnCnt <= TURN_W'(TURN_CYC);
        end
      end
    end
  end

  a_r8_read_burst_drives: assert property (@(posedge clk) disable iff (!rstN)
    (inBurst && burstRd) |-> dirOut);
  a_r9_write_burst_listens: assert property (@(posedge clk) disable iff (!rstN)
    (inBurst && !burstRd) |-> !dirOut);
  a_r6_release_after_turn: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dirOut) |-> $past(turning));
  a_r4_drive_on_word_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dirOut) |-> $past(wordEnd));
endmodule

// File: rtl/bsp_port.sv
module bsp_port
  import bsp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int BURST_W     = 3,
  parameter int TURN_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclkIn,
  input  logic               frameNIn,
  input  logic               polarity,
  input  logic               dataIn,
  input  logic [WORD_W-1:0]  resultWord,
  input  logic               calReq,
  input  logic               calRead,
  input  logic [BURST_W-1:0] calWords,
  output logic [WORD_W-1:0]  rxWord,
  output logic               rxValid,
  output logic               dataOut,
  output logic               dataOe
);
  bsp_strobe_t strb;
  logic capEdge, lchEdge, frameLow;

  bsp_datapath #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .frameNIn(frameNIn),
    .dataIn(dataIn), .polarity(polarity), .resultWord(resultWord),
    .strb(strb), .capEdge(capEdge), .lchEdge(lchEdge), .frameLow(frameLow),
    .rxWord(rxWord), .rxValid(rxValid), .dataOut(dataOut)
  );

  bsp_control #(.WORD_W(WORD_W), .BURST_W(BURST_W), .TURN_CYC(TURN_CYC)) ctl_i (
    .clk(clk), .rstN(rstN), .capEdge(capEdge), .lchEdge(lchEdge),
    .frameLow(frameLow), .calReq(calReq), .calRead(calRead),
    .calWords(calWords), .strb(strb), .dataOe(dataOe)
  );
endmodule

// File: tb/bsp_port_tb.sv
module bsp_port_tb_top;
  localparam int HALF = 8;

  logic clk = 0, rstN = 0;
  logic sclkIn = 1, frameNIn = 1, polarity = 1, dataIn = 0;
  logic [15:0] resultWord = '0;
  logic calReq = 0, calRead = 0;
  logic [2:0] calWords = '0;
  logic [15:0] rxWord;
  logic rxValid, dataOut, dataOe;

  int checks = 0, failures = 0;
  logic [15:0] expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  bsp_port dut_i (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .frameNIn(frameNIn),
    .polarity(polarity), .dataIn(dataIn), .resultWord(resultWord),
    .calReq(calReq), .calRead(calRead), .calWords(calWords),
    .rxWord(rxWord), .rxValid(rxValid), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frameSet(input logic v);
    frameNIn = v;
    waitClk(4);
  endtask

  // drive one word into the block; the scoreboard expects it on rxWord
  task automatic writeWord(input logic [15:0] w, input string tag);
    expQ.push_back(w);
    tagQ.push_back(tag);
    for (int i = 15; i >= 0; i--) begin
      dataIn = w[i];
      sclkIn = ~polarity; waitClk(HALF);
      sclkIn = polarity;  waitClk(HALF);
    end
  endtask

  // clock one word out of the block and compare it bit by bit
  task automatic readWord(input logic [15:0] exp, input string tag);
    logic [15:0] got = '0;
    logic oeAll = 1'b1;
    resultWord = exp;
    for (int i = 15; i >= 0; i--) begin
      sclkIn = ~polarity; waitClk(HALF);
      got[i] = dataOut;
      oeAll = oeAll & dataOe;
      sclkIn = polarity;  waitClk(HALF);
    end
    check(got == exp, {tag, " read word"}, got, exp);
    check(oeAll, {tag, " oe held during read"}, oeAll, 1);
  endtask

  // scoreboard monitor
  logic prevValid = 0;
  always @(negedge clk) begin
    if (rxValid && prevValid) begin
      failures++;
      $display("FAIL R2 rxValid wider than one clock actual=1 expected=0");
    end
    if (rxValid) begin
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected rxValid actual=%0h expected=none", rxWord);
      end else begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rxWord == e, {t, " received word"}, rxWord, e);
      end
    end
    prevValid = rxValid;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    waitClk(3);
    check(dataOe == 0 && rxValid == 0, "R1 reset state", {dataOe, rxValid}, 0);
    rstN = 1;
    waitClk(5);
    check(dataOe == 0, "R1 input after reset", dataOe, 0);

    // R2 R4 R5 R6: pulsed frame, polarity high
    frameSet(0);
    writeWord(16'hA5C3, "R2");
    frameSet(1);
    check(dataOe == 0, "R4 tri-state with frame high", dataOe, 0);
    frameSet(0);
    check(dataOe == 1, "R4 drives with frame low", dataOe, 1);
    readWord(16'h1234, "R5");
    waitClk(2);
    check(dataOe == 0, "R6 released after turnaround", dataOe, 0);
    frameSet(1);

    // R3: polarity low
    polarity = 0; sclkIn = 0; waitClk(6);
    frameSet(0);
    writeWord(16'h0F1E, "R3");
    frameSet(1);
    frameSet(0);
    readWord(16'hBEEF, "R3");
    frameSet(1);
    check(dataOe == 0, "R3 tri-state after read", dataOe, 0);

    // R7: frame tied low, polarity high
    polarity = 1; sclkIn = 1; waitClk(6);
    frameSet(0);
    writeWord(16'h8001, "R7");
    check(dataOe == 1, "R7 turn to output at 16th edge", dataOe, 1);
    readWord(16'h7FFE, "R7");
    waitClk(2);
    check(dataOe == 0, "R7 back to input", dataOe, 0);
    writeWord(16'h3C3C, "R7");
    check(dataOe == 1, "R7 second turn to output", dataOe, 1);
    readWord(16'hC3A5, "R7");
    waitClk(2);

    // R8 R10: read burst of 3 words
    calReq = 1; calRead = 1; calWords = 3'd2;
    writeWord(16'h4242, "R8");
    calReq = 1; calRead = 0; calWords = 3'd5;
    check(dataOe == 1, "R8 output after burst command", dataOe, 1);
    readWord(16'h1111, "R8");
    check(dataOe == 1, "R8 held between burst words", dataOe, 1);
    readWord(16'h2222, "R8");
    frameSet(1);
    check(dataOe == 0, "R10 frame high tri-states in burst", dataOe, 0);
    frameSet(0);
    check(dataOe == 1, "R10 burst resumes after frame pulse", dataOe, 1);
    readWord(16'h3333, "R10");
    waitClk(2);
    check(dataOe == 0, "R8 input after last burst word", dataOe, 0);

    // R9: write burst of 2 data words
    calReq = 1; calRead = 0; calWords = 3'd1;
    writeWord(16'h5A5A, "R9");
    calReq = 0;
    check(dataOe == 0, "R9 input after burst command", dataOe, 0);
    writeWord(16'hDEAD, "R9");
    check(dataOe == 0, "R9 input between data words", dataOe, 0);
    writeWord(16'h0001, "R9");
    check(dataOe == 1, "R9 output after last data word", dataOe, 1);
    readWord(16'h9669, "R9");
    waitClk(2);
    check(dataOe == 0, "R9 released after result", dataOe, 0);
    frameSet(1);

    waitClk(10);
    check(expQ.size() == 0, "R2 all words received", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule